// File: doc/BRIEF.md
# Multi-Channel Serial Audio Port

This block is the master end of a serial audio link. From the core clock it builds a bit clock and a word-select clock. It shifts four output samples per frame onto two stereo data lines, and it deserialises one stereo input line. Each frame lasts 1024 core clocks. That gives 64 bit clocks, split into a left slot of 32 bits and a right slot of 32 bits. Output samples are 20 bits wide and input samples are 16 bits wide. A format input chooses between I2S framing and right-justified framing.

The core exchanges data with the port once per frame. A one-cycle frame strobe marks the first core clock of every frame. The output words and the format present on the inputs at the clock edge that raises the strobe are sent during that frame. At the same edge the stereo pair captured in the previous frame appears on the receive outputs.

A small state machine tracks the slot. BOOT is the reset state and lasts exactly one clock. The transition start moves BOOT to LEFT. The transition half moves LEFT to RIGHT at the middle of the frame. The transition wrap moves RIGHT back to LEFT at the end of the frame.

Top module: `sap_port`

## Requirements
- R1: The bit clock has a period of 16 core clocks. It is low for the first 8 core clocks of each bit and high for the last 8, so every bit period starts on a falling edge.
- R2: A frame is 1024 core clocks, or 64 bit periods. `frame_o` is high for exactly one core clock, the first clock of each frame, and the first frame begins on the first clock after reset is released.
- R3: While reset is held, `bclk_o` is 1, and `ws_o`, `sd_o`, `frame_o`, `rx_left_o` and `rx_right_o` are all 0.
- R4: With `fmt_rj_i` = 0 (I2S), `ws_o` is low for the left slot (bits 0..31) and high for the right slot (bits 32..63). `ws_o` changes one bit period before each slot begins, so it is 1 on bits 31..62 and 0 on bit 63 and bits 0..30.
- R5: In I2S format, slot bit 0 carries bit 19 of the 20-bit word, the MSB, and the bits follow MSB first down to slot bit 19. Slot bits 20..31 are 0.
- R6: With `fmt_rj_i` = 1 (right-justified), `ws_o` is high during the left slot and low during the right slot, changing on the first bit of each slot. Slot bits 0..11 are 0, slot bit 12 carries the MSB, and slot bit 31 carries the LSB.
- R7: Word j of `tx_words_i` occupies bits [20j+19:20j]. Lane k (`sd_o[k]`) sends word 2k in the left slot and word 2k+1 in the right slot.
- R8: `ws_o` and `sd_o` change only on core clock edges where `bclk_o` falls. They stay constant while `bclk_o` is high.
- R9: In I2S format, `sd_i` is sampled at each rising edge of the bit clock. The 16-bit word of each slot is read MSB first from slot bits 0..15, and slot bits 16..31 are ignored.
- R10: In right-justified format, the 16-bit word of each slot is read MSB first from slot bits 16..31, and slot bits 0..15 are ignored.
- R11: The stereo pair received during frame N appears on `rx_left_o` and `rx_right_o` in the clock where `frame_o` starts frame N+1, and holds until the next strobe. Before any frame has completed, both outputs read 0.
- R12: `tx_words_i` and `fmt_rj_i` are sampled only at the edge that raises `frame_o`. Changes made during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_rj_i | input | 1 | Format select: 0 for I2S, 1 for right-justified |
| tx_words_i | input | 80 | Four 20-bit output words, with word j at bits [20j+19:20j] |
| sd_i | input | 1 | Serial stereo input data |
| bclk_o | output | 1 | Bit clock, 16 core clocks per period |
| ws_o | output | 1 | Word-select clock |
| sd_o | output | 2 | Serial output data, one bit per lane |
| rx_left_o | output | 16 | Left sample received in the previous frame |
| rx_right_o | output | 16 | Right sample received in the previous frame |
| frame_o | output | 1 | One-cycle strobe on the first clock of each frame |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the divider and slot parameters are powers of two, so the frame counter wraps without a compare. The bench changes `sd_i` only in the core cycle where the bit clock has just fallen, so the input is steady at the rising-edge sample point. It changes `tx_words_i` and `fmt_rj_i` only one nanosecond after a strobe is seen. Every new value therefore lands well inside a running frame, and the stale frame must ignore it. The bench drives ones into the slot bits that must be ignored, so any receive window placed in the wrong bits would show up in the captured words.

// File: rtl/sap_pkg.sv
package sap_pkg;

    // Slot tracker states of the frame timing generator
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } slot_state_e;

    // Frame layout selected by the core
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_RJ  = 1'b1
    } frame_fmt_e;

endpackage

// File: rtl/sap_timing.sv
module sap_timing
    import sap_pkg::*;
#(
    parameter int DIV    = 16,
    parameter int SLOT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fmt_i,
    output logic                      load_o,
    output logic                      sample_o,
    output logic                      bclk_o,
    output logic                      ws_o,
    output logic                      slot_o,
    output logic [$clog2(SLOT_W)-1:0] pos_o,
    output frame_fmt_e                fmt_q_o
);
    localparam int PH_W       = $clog2(DIV);
    localparam int POS_W      = $clog2(SLOT_W);
    localparam int BIT_W      = POS_W + 1;
    localparam int CNT_W      = PH_W + BIT_W;
    localparam int FRAME      = DIV * 2 * SLOT_W;
    localparam int HALF_FRAME = FRAME / 2;
    localparam logic [CNT_W-1:0] LAST      = CNT_W'(FRAME - 1);
    localparam logic [CNT_W-1:0] MID       = CNT_W'(HALF_FRAME - 1);
    localparam logic [PH_W-1:0]  SAMPLE_PH = PH_W'(DIV / 2 - 1);
    localparam logic [BIT_W-1:0] WS_FIRST  = BIT_W'(SLOT_W - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(2 * SLOT_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PH_W-1:0]  phase;
    logic [BIT_W-1:0] bit_idx;
    slot_state_e      state_q, state_d;
    frame_fmt_e       fmt_q;

    assign phase   = cnt_q[PH_W-1:0];
    assign bit_idx = cnt_q[CNT_W-1:PH_W];

    // Core-clock counter; reset parks it on the last clock of a frame
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= LAST;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    // Format is frozen for a whole frame
    always_ff @(posedge clk) begin
        if (!rst_n)      fmt_q <= FMT_I2S;
        else if (load_o) fmt_q <= frame_fmt_e'(fmt_i);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Transitions: start, half, wrap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_LEFT;
            ST_LEFT:  if (cnt_q == MID)  state_d = ST_RIGHT;
            ST_RIGHT: if (cnt_q == LAST) state_d = ST_LEFT;
            default:  state_d = ST_BOOT;
        endcase
    end

    // Outputs
    always_comb begin
        load_o   = (cnt_q == LAST);
        sample_o = (phase == SAMPLE_PH);
        bclk_o   = phase[PH_W-1];
        slot_o   = (state_q == ST_RIGHT);
        pos_o    = bit_idx[POS_W-1:0];
        fmt_q_o  = fmt_q;
        ws_o     = 1'b0;
        unique case (fmt_q)
            FMT_I2S: ws_o = (bit_idx >= WS_FIRST) && (bit_idx != BIT_LAST);
            FMT_RJ:  ws_o = (state_q == ST_LEFT);
        endcase
    end

    assert_state_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RIGHT) |-> cnt_q[CNT_W-1]);
    assert_state_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEFT) |-> !cnt_q[CNT_W-1]);
    assert_boot_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |-> load_o);

endmodule

// File: rtl/sap_tx_lane.sv
module sap_tx_lane
    import sap_pkg::*;
#(
    parameter int OUT_W  = 20,
    parameter int SLOT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [OUT_W-1:0]          left_i,
    input  logic [OUT_W-1:0]          right_i,
    input  frame_fmt_e                fmt_i,
    input  logic                      slot_i,
    input  logic [$clog2(SLOT_W)-1:0] pos_i,
    output logic                      sd_o
);
    localparam int POS_W = $clog2(SLOT_W);
    localparam int PAD_W = SLOT_W - OUT_W;

    logic [OUT_W-1:0]  left_q, right_q, word;
    logic [SLOT_W-1:0] image;
    logic [POS_W-1:0]  sel;

    // Words held for the full frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (load_i) begin
            left_q  <= left_i;
            right_q <= right_i;
        end
    end

    // Slot image: word placed at the head (I2S) or at the tail (right-justified)
    always_comb begin
        word  = slot_i ? right_q : left_q;
        image = '0;
        unique case (fmt_i)
            FMT_I2S: image = {word, {PAD_W{1'b0}}};
            FMT_RJ:  image = {{PAD_W{1'b0}}, word};
        endcase
        sel  = POS_W'(SLOT_W - 1) - pos_i;
        sd_o = image[sel];
    end

endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int SLOT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_i,
    input  logic                      load_i,
    input  frame_fmt_e                fmt_i,
    input  logic                      slot_i,
    input  logic [$clog2(SLOT_W)-1:0] pos_i,
    input  logic                      sd_i,
    output logic [IN_W-1:0]           left_o,
    output logic [IN_W-1:0]           right_o
);
    logic [IN_W-1:0] left_sh, right_sh;
    logic            in_win;

    // Capture window inside the slot
    always_comb begin
        in_win = 1'b0;
        unique case (fmt_i)
            FMT_I2S: in_win = (int'(pos_i) < IN_W);
            FMT_RJ:  in_win = (int'(pos_i) >= SLOT_W - IN_W);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_sh  <= '0;
            right_sh <= '0;
            left_o   <= '0;
            right_o  <= '0;
        end else begin
            if (sample_i && in_win) begin
                if (slot_i) right_sh <= {right_sh[IN_W-2:0], sd_i};
                else        left_sh  <= {left_sh[IN_W-2:0], sd_i};
            end
            if (load_i) begin
                left_o  <= left_sh;
                right_o <= right_sh;
            end
        end
    end

    assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/sap_port.sv
module sap_port
    import sap_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int OUT_W  = 20,
    parameter int IN_W   = 16,
    parameter int SLOT_W = 32,
    parameter int DIV    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fmt_rj_i,
    input  logic [2*LANES*OUT_W-1:0] tx_words_i,
    input  logic                     sd_i,
    output logic                     bclk_o,
    output logic                     ws_o,
    output logic [LANES-1:0]         sd_o,
    output logic [IN_W-1:0]          rx_left_o,
    output logic [IN_W-1:0]          rx_right_o,
    output logic                     frame_o
);
    localparam int POS_W = $clog2(SLOT_W);
    localparam int PAD_W = SLOT_W - OUT_W;

    logic             load, sample, slot;
    logic [POS_W-1:0] pos;
    frame_fmt_e       fmt_q;

    sap_timing #(.DIV(DIV), .SLOT_W(SLOT_W)) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_i    (fmt_rj_i),
        .load_o   (load),
        .sample_o (sample),
        .bclk_o   (bclk_o),
        .ws_o     (ws_o),
        .slot_o   (slot),
        .pos_o    (pos),
        .fmt_q_o  (fmt_q)
    );

    // Lane k carries words 2k (left) and 2k+1 (right), R7
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sap_tx_lane #(.OUT_W(OUT_W), .SLOT_W(SLOT_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .left_i  (tx_words_i[(2*g)*OUT_W +: OUT_W]),
            .right_i (tx_words_i[(2*g+1)*OUT_W +: OUT_W]),
            .fmt_i   (fmt_q),
            .slot_i  (slot),
            .pos_i   (pos),
            .sd_o    (sd_o[g])
        );
    end

    sap_rx #(.IN_W(IN_W), .SLOT_W(SLOT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .load_i   (load),
        .fmt_i    (fmt_q),
        .slot_i   (slot),
        .pos_i    (pos),
        .sd_i     (sd_i),
        .left_o   (rx_left_o),
        .right_o  (rx_right_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) frame_o <= 1'b0;
        else        frame_o <= load;
    end

    assert_frame_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> $fell(bclk_o));
    assert_frame_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o);
    assert_ws_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_o) |-> $fell(bclk_o));
    assert_sd_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_o) |-> $fell(bclk_o));
    assert_i2s_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q == FMT_I2S && int'(pos) >= OUT_W) |-> (sd_o == '0));
    assert_rj_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q == FMT_RJ && int'(pos) < PAD_W) |-> (sd_o == '0));

endmodule

// File: tb/sap_port_tb.sv
`timescale 1ns/1ps
module sap_port_tb;
    typedef struct packed {
        logic        mode;
        logic [79:0] words;
        logic [15:0] rl;
        logic [15:0] rr;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_rj_i = 1'b0;
    logic [79:0] tx_words_i = '0;
    logic        sd_i = 1'b0;
    logic        bclk_o, ws_o, frame_o;
    logic [1:0]  sd_o;
    logic [15:0] rx_left_o, rx_right_o;

    int checks = 0;
    int fails = 0;
    int frames_done = 0;
    bit finished = 1'b0;
    item_t q[$];

    always #2.5 clk = ~clk;

    sap_port u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_rj_i(fmt_rj_i), .tx_words_i(tx_words_i),
        .sd_i(sd_i), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o),
        .rx_left_o(rx_left_o), .rx_right_o(rx_right_o), .frame_o(frame_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_ws(logic m, int b);
        if (!m) return (((b + 1) % 64) >= 32);
        return (b < 32);
    endfunction

    function automatic logic exp_sd(logic m, logic [19:0] w, int p);
        if (!m) return (p < 20) ? w[19 - p] : 1'b0;
        return (p >= 12) ? w[31 - p] : 1'b0;
    endfunction

    // Bits outside the capture window are driven high; they must be ignored (R9, R10)
    function automatic logic rx_bit(logic m, logic [15:0] v, int p);
        if (!m) return (p < 16) ? v[15 - p] : 1'b1;
        return (p >= 16) ? v[31 - p] : 1'b1;
    endfunction

    task automatic push_frame(input item_t it);
        fmt_rj_i   = it.mode;
        tx_words_i = it.words;
        q.push_back(it);
    endtask

    function automatic item_t mk(logic m, logic [19:0] w0, logic [19:0] w1,
                                 logic [19:0] w2, logic [19:0] w3,
                                 logic [15:0] l, logic [15:0] r);
        item_t it;
        it.mode  = m;
        it.words = {w3, w2, w1, w0};
        it.rl    = l;
        it.rr    = r;
        return it;
    endfunction

    // Monitor: pops one item per frame and checks every bit
    initial begin : monitor
        item_t cur;
        item_t prev;
        bit    started;
        prev    = '0;
        started = 1'b0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (started) chk(frame_o == 1'b1, "R2 frame strobe period", frame_o, 1);
            if (frame_o || started) begin
                if (q.size() == 0) break;
                started = 1'b1;
                cur = q.pop_front();
                chk(rx_left_o == prev.rl, prev.mode ? "R10 R11 rx left" : "R9 R11 rx left", rx_left_o, prev.rl);
                chk(rx_right_o == prev.rr, prev.mode ? "R10 R11 rx right" : "R9 R11 rx right", rx_right_o, prev.rr);
                for (int c = 0; c < 1024; c++) begin
                    int p, b, pos, slot;
                    logic [1:0] esd;
                    if (c > 0) @(negedge clk);
                    p = c % 16; b = c / 16; pos = b % 32; slot = b / 32;
                    if (p == 0) sd_i = rx_bit(cur.mode, slot ? cur.rr : cur.rl, pos);
                    esd[0] = exp_sd(cur.mode, cur.words[(0 + slot) * 20 +: 20], pos);
                    esd[1] = exp_sd(cur.mode, cur.words[(2 + slot) * 20 +: 20], pos);
                    if (p == 4) begin
                        chk(bclk_o == 1'b0, "R1 bclk low half", bclk_o, 0);
                        chk(ws_o == exp_ws(cur.mode, b), cur.mode ? "R6 ws" : "R4 ws", ws_o, exp_ws(cur.mode, b));
                        chk(sd_o == esd, cur.mode ? "R6 R7 R12 sd" : "R5 R7 R12 sd", sd_o, esd);
                        if (c > 0) chk(frame_o == 1'b0, "R2 strobe width", frame_o, 0);
                    end
                    if (p == 12) begin
                        chk(bclk_o == 1'b1, "R1 bclk high half", bclk_o, 1);
                        chk(ws_o == exp_ws(cur.mode, b) && sd_o == esd, "R8 stable while high",
                            {ws_o, sd_o}, {exp_ws(cur.mode, b), esd});
                    end
                end
                prev = cur;
                frames_done++;
            end
        end
    end

    // Driver
    initial begin : driver
        item_t items[9];
        items[0] = mk(1'b0, 20'hFFFFF, 20'h00001, 20'h80000, 20'hAAAAA, 16'hFFFF, 16'h0001);
        items[1] = mk(1'b1, 20'h12345, 20'hFEDCB, 20'h55555, 20'h0F0F0, 16'h8001, 16'h7FFE);
        items[2] = mk(1'b0, 20'h00000, 20'h00000, 20'h00000, 20'h00000, 16'h0000, 16'h0000);
        items[3] = mk(1'b1, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 16'hFFFF, 16'hFFFF);
        items[4] = mk(1'b0, 20'h80001, 20'h40002, 20'hC3C3C, 20'h3C3C3, 16'hA5A5, 16'h5A5A);
        items[5] = mk(1'b1, 20'h80001, 20'h00001, 20'h80000, 20'h13579, 16'h0001, 16'h8000);
        items[6] = mk(1'b1, 20'h2468A, 20'hBDF13, 20'h11111, 20'hEEEEE, 16'h1234, 16'hFEDC);
        items[7] = mk(1'b0, 20'h7FFFE, 20'hAAAAA, 20'h55555, 20'h00010, 16'h00FF, 16'hFF00);
        items[8] = mk(1'b0, 20'h0, 20'h0, 20'h0, 20'h0, 16'h0, 16'h0);

        push_frame(items[0]);
        // R3: reset state
        repeat (3) @(negedge clk);
        chk(bclk_o == 1'b1, "R3 reset bclk", bclk_o, 1);
        chk(ws_o == 1'b0, "R3 reset ws", ws_o, 0);
        chk(sd_o == 2'b00, "R3 reset sd", sd_o, 0);
        chk(frame_o == 1'b0, "R3 reset strobe", frame_o, 0);
        chk(rx_left_o == 16'h0 && rx_right_o == 16'h0, "R3 reset rx", {rx_left_o, rx_right_o}, 0);
        rst_n = 1'b1;
        for (int i = 1; i < 9; i++) begin
            @(negedge clk);
            while (!frame_o) @(negedge clk);
            #1;
            push_frame(items[i]);
        end
        wait (frames_done == 9);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d frames expected 9", frames_done);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule